// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a 32-bit processor and picks the following fetch address on every clock. It always forms the sequential successor, which is the current address plus four. It then selects one of four candidates using a transfer class code from the decoder and a condition result from the ALU. The candidates are the sequential successor, a PC-relative branch target, a region-relative (pseudo-direct) jump target, and a target taken from a register.

For call-type transfers the block also presents the return address, together with a strobe that marks the cycle in which the address is meant to be written back. A register target with nonzero low bits raises a flag. The PC is still loaded with a word-aligned version of that target.

The block drives no memory and reads no register file. The instruction word, the class code, the condition bit and the source register value all arrive from outside, and the unit reacts to them within the same cycle.

Top module: `npc_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads `pc` with the parameter `RESET_VEC`, which defaults to 0.
- R2: Class code 0 (sequential) and the unused codes 6 and 7 load `pc + 4` at the next edge, and `br_taken` has no effect on them.
- R3: Class code 1 (branch) with `br_taken` high loads `pc + 4 + (instr[15:0] sign-extended to 32 bits, times 4)`.
- R4: Class code 1 with `br_taken` low loads `pc + 4`.
- R5: Class codes 2 (jump) and 3 (jump with link) load an address formed from three parts. Bits 31..28 are bits 31..28 of `pc + 4`. Bits 27..2 are `instr[25:0]`. Bits 1..0 are zero.
- R6: Class codes 4 (register jump) and 5 (register jump with link) load `rs_value` with its two low bits cleared.
- R7: `link_value` always equals `pc + 4`. `link_valid` is high in exactly those cycles whose class code is 3 or 5.
- R8: `rs_misaligned` is high in exactly those cycles whose class code is 4 or 5 and in which `rs_value[1:0]` is nonzero.
- R9: All address sums wrap modulo 2^32. For example, a sequential step from `32'hFFFF_FFFC` gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word of the current cycle |
| xfer_class | input | 3 | Transfer class code from the decoder |
| br_taken | input | 1 | Branch condition result from the ALU |
| rs_value | input | 32 | Contents of the source register rs |
| pc | output | 32 | Current program counter |
| link_value | output | 32 | Return address (pc + 4) |
| link_valid | output | 1 | Return address is to be written this cycle |
| rs_misaligned | output | 1 | Register jump target has nonzero low bits |

## Verification
Two functions can fall in the same cycle. A register jump with link whose `rs_value` has nonzero low bits must produce the return address, raise the misalignment flag, and load a cleaned target, all at once. The bench provokes this collision directly and also mixes it into a long random stream. It judges each of the three results separately against its own model: the return address comes from the old `pc`, and the new `pc` comes from the masked register value. A second collision is checked at the top of the address space. A register jump there places `pc` at the last word, so the following sequential step and the branch arithmetic must wrap, and the region bits of a jump must come from the wrapped successor.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int ADDR_W   = 32;
  localparam int IMM_W    = 16;
  localparam int TGT_W    = 26;
  localparam int REGION_W = ADDR_W - TGT_W - 2;
  localparam int ALIGN_W  = 2;
  localparam int NSRC     = 4;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  typedef enum logic [2:0] {
    XC_SEQ           = 3'd0,
    XC_BRANCH        = 3'd1,
    XC_JUMP          = 3'd2,
    XC_JUMP_LINK     = 3'd3,
    XC_REG_JUMP      = 3'd4,
    XC_REG_JUMP_LINK = 3'd5
  } xfer_class_e;

  // index of each candidate inside the one-hot source vector
  localparam int SRC_SEQ = 0;
  localparam int SRC_BR  = 1;
  localparam int SRC_PD  = 2;
  localparam int SRC_REG = 3;

  typedef logic [ADDR_W-1:0] addr_t;

  function automatic addr_t f_successor(input addr_t cur);
    return cur + STEP;
  endfunction

  function automatic addr_t f_branch(input addr_t succ, input logic [IMM_W-1:0] imm);
    addr_t off;
    off = {{(ADDR_W-IMM_W-ALIGN_W){imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
    return succ + off;
  endfunction

  function automatic addr_t f_pseudo(input addr_t succ, input logic [TGT_W-1:0] tgt);
    return {succ[ADDR_W-1 -: REGION_W], tgt, {ALIGN_W{1'b0}}};
  endfunction

  function automatic addr_t f_word_align(input addr_t a);
    return {a[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  endfunction
endpackage

// File: rtl/npc_targets.sv
module npc_targets
  import npc_pkg::*;
(
  input  addr_t                 cur_pc,
  input  logic [IMM_W-1:0]      imm_field,
  input  logic [TGT_W-1:0]      tgt_field,
  input  addr_t                 rs_val,
  output addr_t                 seq_addr,
  output addr_t                 br_addr,
  output addr_t                 pd_addr,
  output addr_t                 reg_addr,
  output logic                  reg_low_bits
);
  assign seq_addr     = f_successor(cur_pc);
  assign br_addr      = f_branch(seq_addr, imm_field);
  assign pd_addr      = f_pseudo(seq_addr, tgt_field);
  assign reg_addr     = f_word_align(rs_val);
  assign reg_low_bits = |rs_val[ALIGN_W-1:0];
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
(
  input  logic [2:0]            cls_code,
  input  logic                  cond,
  input  addr_t [NSRC-1:0]      cand,
  output logic [NSRC-1:0]       sel,
  output addr_t                 next_pc,
  output logic                  is_link,
  output logic                  is_reg
);
  xfer_class_e cls;
  assign cls = xfer_class_e'(cls_code);

  always_comb begin
    sel     = '0;
    is_link = 1'b0;
    is_reg  = 1'b0;
    unique case (cls)
      XC_BRANCH:        sel[cond ? SRC_BR : SRC_SEQ] = 1'b1;
      XC_JUMP:          sel[SRC_PD] = 1'b1;
      XC_JUMP_LINK:     begin sel[SRC_PD] = 1'b1; is_link = 1'b1; end
      XC_REG_JUMP:      begin sel[SRC_REG] = 1'b1; is_reg = 1'b1; end
      XC_REG_JUMP_LINK: begin sel[SRC_REG] = 1'b1; is_reg = 1'b1; is_link = 1'b1; end
      default:          sel[SRC_SEQ] = 1'b1;
    endcase
  end

  // AND-OR mux over the one-hot select
  addr_t [NSRC-1:0] masked;
  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_mask
      assign masked[gi] = cand[gi] & {ADDR_W{sel[gi]}};
    end
  endgenerate

  always_comb begin
    next_pc = '0;
    for (int k = 0; k < NSRC; k++) next_pc = next_pc | masked[k];
  end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg
  import npc_pkg::*;
#(
  parameter addr_t RESET_VEC = '0
) (
  input  logic  clk,
  input  logic  rst,
  input  addr_t nxt,
  output addr_t cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= RESET_VEC;
    else     cur <= nxt;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] instr,
  input  logic [2:0]  xfer_class,
  input  logic        br_taken,
  input  logic [31:0] rs_value,
  output logic [31:0] pc,
  output logic [31:0] link_value,
  output logic        link_valid,
  output logic        rs_misaligned
);
  addr_t            seq_addr, br_addr, pd_addr, reg_addr, next_pc;
  addr_t [NSRC-1:0] cand;
  logic  [NSRC-1:0] sel;
  logic             is_link, is_reg, reg_low_bits;
  logic             unused_opcode;

  assign unused_opcode = ^instr[ADDR_W-1:TGT_W];

  npc_targets u_targets (
    .cur_pc       (pc),
    .imm_field    (instr[IMM_W-1:0]),
    .tgt_field    (instr[TGT_W-1:0]),
    .rs_val       (rs_value),
    .seq_addr     (seq_addr),
    .br_addr      (br_addr),
    .pd_addr      (pd_addr),
    .reg_addr     (reg_addr),
    .reg_low_bits (reg_low_bits)
  );

  assign cand[SRC_SEQ] = seq_addr;
  assign cand[SRC_BR]  = br_addr;
  assign cand[SRC_PD]  = pd_addr;
  assign cand[SRC_REG] = reg_addr;

  npc_select u_select (
    .cls_code (xfer_class),
    .cond     (br_taken),
    .cand     (cand),
    .sel      (sel),
    .next_pc  (next_pc),
    .is_link  (is_link),
    .is_reg   (is_reg)
  );

  npc_pc_reg #(.RESET_VEC(RESET_VEC)) u_pc (
    .clk (clk),
    .rst (rst),
    .nxt (next_pc),
    .cur (pc)
  );

  assign link_value    = seq_addr;
  assign link_valid    = is_link;
  assign rs_misaligned = is_reg & reg_low_bits;

  // ---------------- assertions ----------------
  a_r1_reset_vector: assert property (@(posedge clk) rst |=> pc == RESET_VEC);

  a_r2_single_source: assert property (@(posedge clk) disable iff (rst) $onehot(sel));

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (xfer_class == 3'd0 || xfer_class >= 3'd6) |=> pc == $past(pc) + 32'd4);

  a_r3_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (xfer_class == 3'd1 && br_taken) |=>
      pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  a_r4_branch_fall: assert property (@(posedge clk) disable iff (rst)
    (xfer_class == 3'd1 && !br_taken) |=> pc == $past(pc) + 32'd4);

  a_r5_pseudo_low: assert property (@(posedge clk) disable iff (rst)
    (xfer_class == 3'd2 || xfer_class == 3'd3) |=>
      pc[27:0] == {$past(instr[25:0]), 2'b00});

  a_r6_reg_target: assert property (@(posedge clk) disable iff (rst)
    (xfer_class == 3'd4 || xfer_class == 3'd5) |=> pc[31:2] == $past(rs_value[31:2]));

  a_r7_link_offset: assert property (@(posedge clk) disable iff (rst)
    link_valid |-> (link_value - pc) == 32'd4);

  a_r8_misalign_cleaned: assert property (@(posedge clk) disable iff (rst)
    rs_misaligned |=> pc[1:0] == 2'b00);
endmodule

// File: tb/npc_unit_tb.sv
`timescale 1ns/100ps
module npc_unit_tb;
  localparam logic [31:0] RV = 32'h0000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [2:0]  xfer_class = '0;
  logic        br_taken = 1'b0;
  logic [31:0] rs_value = '0;
  logic [31:0] pc, link_value;
  logic        link_valid, rs_misaligned;

  npc_unit #(.RESET_VEC(RV)) u_dut (
    .clk(clk), .rst(rst), .instr(instr), .xfer_class(xfer_class),
    .br_taken(br_taken), .rs_value(rs_value), .pc(pc),
    .link_value(link_value), .link_valid(link_valid), .rs_misaligned(rs_misaligned)
  );

  always #2.5 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  logic [31:0] m_pc = RV;
  string pc_tag = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_next(input logic [31:0] cur, input logic [2:0] c,
      input logic [31:0] ins, input logic t, input logic [31:0] rv);
    logic [31:0] nxt4, off;
    nxt4 = cur + 32'd4;
    off  = {{16{ins[15]}}, ins[15:0]} * 32'd4;
    case (c)
      3'd1:       return t ? nxt4 + off : nxt4;
      3'd2, 3'd3: return (nxt4 & 32'hF000_0000) | ((ins & 32'h03FF_FFFF) << 2);
      3'd4, 3'd5: return rv & 32'hFFFF_FFFC;
      default:    return nxt4;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c, input logic t);
    case (c)
      3'd1:       return t ? "R3" : "R4";
      3'd2, 3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      default:    return "R2";
    endcase
  endfunction

  task automatic step(input logic [2:0] c, input logic [31:0] ins, input logic t,
                      input logic [31:0] rv);
    bit exp_lv, exp_mis;
    @(negedge clk);
    chk(pc === m_pc, (m_pc == 32'h0 && pc_tag == "R2") ? "R9" : pc_tag, "pc", pc, m_pc);
    rst = 1'b0; xfer_class = c; instr = ins; br_taken = t; rs_value = rv;
    #1;
    exp_lv  = (c == 3'd3 || c == 3'd5);
    exp_mis = (c == 3'd4 || c == 3'd5) && (rv[1:0] != 2'b00);
    chk(link_value === m_pc + 32'd4, "R7", "link_value", link_value, m_pc + 32'd4);
    chk(link_valid === exp_lv, "R7", "link_valid", {31'b0, link_valid}, {31'b0, exp_lv});
    chk(rs_misaligned === exp_mis, "R8", "rs_misaligned", {31'b0, rs_misaligned}, {31'b0, exp_mis});
    m_pc   = model_next(m_pc, c, ins, t, rv);
    pc_tag = tag_of(c, t);
  endtask

  task automatic do_reset(input logic [2:0] c, input logic [31:0] rv);
    @(negedge clk);
    chk(pc === m_pc, pc_tag, "pc", pc, m_pc);
    rst = 1'b1; xfer_class = c; rs_value = rv; instr = 32'h0123_4567; br_taken = 1'b1;
    m_pc = RV; pc_tag = "R1";
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R2: sequential, with condition high ignored, and unused codes
    step(3'd0, 32'h0, 1'b0, 32'h0);
    step(3'd0, 32'hFFFF_FFFF, 1'b1, 32'h3);
    step(3'd6, 32'h0, 1'b1, 32'h0);
    step(3'd7, 32'h0, 1'b0, 32'h0);
    // R3 forward and backward, R4 not taken
    step(3'd1, 32'h0000_0010, 1'b1, 32'h0);
    step(3'd1, 32'h0000_FFF8, 1'b1, 32'h0);
    step(3'd1, 32'h0000_7FFF, 1'b0, 32'h0);
    // R5 jump and jump-with-link
    step(3'd2, 32'h0812_3456, 1'b0, 32'h0);
    step(3'd3, 32'h03FF_FFFF, 1'b0, 32'h0);
    // R6 aligned register jump into upper region
    step(3'd4, 32'h0, 1'b0, 32'hF000_1000);
    step(3'd2, 32'h0000_0040, 1'b0, 32'h0);
    // collision: link + misalign + register target (R6, R7, R8)
    step(3'd5, 32'h0, 1'b0, 32'h8000_0007);
    step(3'd4, 32'h0, 1'b1, 32'hFFFF_FFFE);
    // R9 wrap on sequential step and on branch
    step(3'd0, 32'h0, 1'b0, 32'h0);
    step(3'd4, 32'h0, 1'b0, 32'hFFFF_FFF8);
    step(3'd1, 32'h0000_0002, 1'b1, 32'h0);
    step(3'd0, 32'h0, 1'b0, 32'h0);
    // R1 reset mid-run while a jump is presented
    do_reset(3'd5, 32'h1234_5679);
    step(3'd0, 32'h0, 1'b0, 32'h0);
    // random stream with occasional resets
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 49) == 0) do_reset(3'($urandom_range(0, 7)), $urandom);
      else step(3'($urandom_range(0, 7)), $urandom, 1'($urandom_range(0, 1)), $urandom);
    end
    @(negedge clk);
    chk(pc === m_pc, pc_tag, "pc", pc, m_pc);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule